// File: doc/BRIEF.md
# Trap Entry Sequencer

This block decides, once per clock, whether a small 32-bit in-order core must leave its normal instruction stream for a trap, and if so computes everything the core writes at that moment. Four sources compete: an MMU fault, a hardware exception, a debug break and an external interrupt. The core presents its current PC, the branch target, three instruction-state flags (delay slot, immediate prefix pending, branch-with-immediate) and its current status byte. On the clock edge that accepts a trap, the block registers a one-cycle redirect strobe together with the vector PC, the index and value of the register that must hold the resume address, and the updated status byte.

The same strobe tells the core to clear its instruction-state flags and to drop any load reservation. For the two exception kinds the block also keeps an exception-status delay-slot bit and a saved branch target, which stay valid until the next exception. The core owns its register file and status register; it applies the block's outputs while the strobe is high.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, redirect_o is 0 and ret_idx_o, ret_addr_o, new_pc_o, stat_o, esr_ds_o and btr_o are all 0.
- R2: At most one trap is taken per cycle; when several requests are eligible the MMU fault wins, then the hardware exception, then the break, then the interrupt.
- R3: An interrupt is accepted only when irq_req is 1, status bit 0 (interrupt enable) is 1, status bits 2 (exception active) and 1 (break active) are 0, and both in_delay and in_imm are 0.
- R4: When cfg_exc_en is 0 a hardware exception request produces no trap and does not disturb esr_ds_o or btr_o; a lower-priority request in the same cycle is served instead.
- R5: The vector PC is VEC_BASE+0x10 for an interrupt, VEC_BASE+0x18 for a break and VEC_BASE+0x20 for either exception.
- R6: An interrupt writes cur_pc to register 14 and clears status bit 0.
- R7: A break writes cur_pc to register 16 and sets status bit 1.
- R8: A hardware exception writes cur_pc+4 to register 17 and sets status bit 2.
- R9: An MMU fault writes to register 17 and sets status bit 2; the value is cur_pc-8 if in_delay and in_bimm are set, cur_pc-4 if only in_delay is set, cur_pc-4 if in_imm is set without in_delay, and cur_pc otherwise.
- R10: On either exception esr_ds_o takes the value of in_delay and, only when in_delay is 1, btr_o takes branch_tgt; both hold their values on every other cycle.
- R11: On every trap status bit 6 takes the old bit 5 (virtual memory), bit 4 takes the old bit 3 (user mode), bits 5 and 3 become 0, and every bit not named by the trap kind passes through unchanged.
- R12: redirect_o is high for exactly the cycle after each accepted trap and low in every cycle after a cycle with no accepted trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_req | input | 1 | External interrupt request (level) |
| hwx_req | input | 1 | Hardware exception request |
| mmu_req | input | 1 | MMU fault request |
| brk_req | input | 1 | Debug break request |
| cfg_exc_en | input | 1 | Configuration: hardware exceptions supported |
| cur_pc | input | 32 | PC of the instruction at the trap point |
| branch_tgt | input | 32 | Pending branch target |
| in_delay | input | 1 | Current instruction sits in a delay slot |
| in_imm | input | 1 | Current instruction follows an immediate prefix |
| in_bimm | input | 1 | The branch owning the delay slot used an immediate prefix |
| stat_i | input | 8 | Current status byte |
| redirect_o | output | 1 | One-cycle strobe: apply outputs, clear flags, drop reservation |
| new_pc_o | output | 32 | Vector PC |
| ret_idx_o | output | 5 | Register index for the resume address |
| ret_addr_o | output | 32 | Resume address |
| stat_o | output | 8 | Updated status byte |
| esr_ds_o | output | 1 | Exception-status delay-slot bit |
| btr_o | output | 32 | Saved branch target |

## Verification
The assertions rely on the core never presenting an immediate prefix inside a delay slot and never raising the branch-with-immediate flag outside a delay slot; an input check flags any such combination. The random stimulus keeps to this by drawing the delay-slot flag first, forcing the prefix flag low when it is set and deriving the branch-with-immediate flag only from it. Status bytes, PCs, targets and requests are otherwise unconstrained, and directed cycles cover each interrupt blocking condition, disabled hardware exceptions and all four MMU resume cases.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [2:0] {
    TK_NONE = 3'd0,
    TK_IRQ  = 3'd1,
    TK_BRK  = 3'd2,
    TK_HWX  = 3'd3,
    TK_MMU  = 3'd4
  } trap_kind_e;

  // Status byte layout: each saved copy sits one bit above its live bit.
  typedef struct packed {
    logic spare;
    logic vm_save;
    logic vm;
    logic um_save;
    logic um;
    logic exc_act;
    logic brk_act;
    logic int_en;
  } stat_t;

  localparam logic [7:0] ST_LIVE_MODES = 8'h28;
  localparam logic [7:0] ST_ALL_MODES  = 8'h78;

  localparam int unsigned OFF_IRQ = 32'h10;
  localparam int unsigned OFF_BRK = 32'h18;
  localparam int unsigned OFF_EXC = 32'h20;

  localparam int unsigned IDX_IRQ = 14;
  localparam int unsigned IDX_BRK = 16;
  localparam int unsigned IDX_EXC = 17;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_req,
  input  logic       hwx_req,
  input  logic       mmu_req,
  input  logic       brk_req,
  input  logic       cfg_exc_en,
  input  stat_t      stat,
  input  logic       in_delay,
  input  logic       in_imm,
  output trap_kind_e kind
);

  localparam int NSRC = 4;

  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] blocked;

  // Index 0 is the highest priority.
  always_comb begin
    elig[0] = mmu_req;
    elig[1] = hwx_req & cfg_exc_en;
    elig[2] = brk_req;
    elig[3] = irq_req & stat.int_en & ~stat.exc_act & ~stat.brk_act
              & ~in_delay & ~in_imm;
  end

  assign blocked[0] = 1'b0;
  for (genvar g = 1; g < NSRC; g++) begin : g_chain
    assign blocked[g] = blocked[g-1] | elig[g-1];
  end
  assign grant = elig & ~blocked;

  always_comb begin
    kind = TK_NONE;
    unique case (1'b1)
      grant[0]: kind = TK_MMU;
      grant[1]: kind = TK_HWX;
      grant[2]: kind = TK_BRK;
      grant[3]: kind = TK_IRQ;
      default:  kind = TK_NONE;
    endcase
  end

  p_onehot_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_mmu_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_req |-> kind == TK_MMU);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kind == TK_IRQ |-> irq_req && stat.int_en && !stat.exc_act && !stat.brk_act
                       && !in_delay && !in_imm);

  p_hwx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_exc_en |-> kind != TK_HWX);

endmodule

// File: rtl/trap_resume_calc.sv
module trap_resume_calc
  import trap_pkg::*;
#(
  parameter int unsigned           XLEN     = 32,
  parameter int unsigned           RIDX_W   = 5,
  parameter logic [XLEN-1:0]       VEC_BASE = '0
) (
  input  trap_kind_e        kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              in_delay,
  input  logic              in_imm,
  input  logic              in_bimm,
  output logic [RIDX_W-1:0] ret_idx,
  output logic [XLEN-1:0]   ret_addr,
  output logic [XLEN-1:0]   vec_pc
);

  localparam logic [XLEN-1:0] VEC_IRQ = VEC_BASE + XLEN'(OFF_IRQ);
  localparam logic [XLEN-1:0] VEC_BRK = VEC_BASE + XLEN'(OFF_BRK);
  localparam logic [XLEN-1:0] VEC_EXC = VEC_BASE + XLEN'(OFF_EXC);
  localparam logic [XLEN-1:0] WORD    = XLEN'(4);
  localparam logic [XLEN-1:0] DWORD   = XLEN'(8);

  logic [XLEN-1:0] mmu_back;
  logic [XLEN-1:0] mmu_ret;

  // MMU faults re-run the owning branch or prefix so the fault is replayed.
  always_comb begin
    if (in_delay) begin
      mmu_back = in_bimm ? DWORD : WORD;
    end else if (in_imm) begin
      mmu_back = WORD;
    end else begin
      mmu_back = '0;
    end
    mmu_ret = cur_pc - mmu_back;
  end

  always_comb begin
    ret_idx  = '0;
    ret_addr = '0;
    vec_pc   = '0;
    unique case (kind)
      TK_IRQ: begin
        ret_idx  = RIDX_W'(IDX_IRQ);
        ret_addr = cur_pc;
        vec_pc   = VEC_IRQ;
      end
      TK_BRK: begin
        ret_idx  = RIDX_W'(IDX_BRK);
        ret_addr = cur_pc;
        vec_pc   = VEC_BRK;
      end
      TK_HWX: begin
        ret_idx  = RIDX_W'(IDX_EXC);
        ret_addr = cur_pc + WORD;
        vec_pc   = VEC_EXC;
      end
      TK_MMU: begin
        ret_idx  = RIDX_W'(IDX_EXC);
        ret_addr = mmu_ret;
        vec_pc   = VEC_EXC;
      end
      default: begin
        ret_idx  = '0;
        ret_addr = '0;
        vec_pc   = '0;
      end
    endcase
  end

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
  import trap_pkg::*;
(
  input  trap_kind_e kind,
  input  stat_t      stat_in,
  output stat_t      stat_out
);

  logic [7:0] saved;
  logic [7:0] shifted;

  always_comb begin
    saved   = (stat_in & ST_LIVE_MODES) << 1;
    shifted = (stat_in & ~ST_ALL_MODES) | saved;
    stat_out = stat_t'(shifted);
    unique case (kind)
      TK_IRQ:         stat_out.int_en  = 1'b0;
      TK_BRK:         stat_out.brk_act = 1'b1;
      TK_HWX, TK_MMU: stat_out.exc_act = 1'b1;
      default:        stat_out = stat_in;
    endcase
  end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     RIDX_W   = 5,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              hwx_req,
  input  logic              mmu_req,
  input  logic              brk_req,
  input  logic              cfg_exc_en,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   branch_tgt,
  input  logic              in_delay,
  input  logic              in_imm,
  input  logic              in_bimm,
  input  logic [7:0]        stat_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [RIDX_W-1:0] ret_idx_o,
  output logic [XLEN-1:0]   ret_addr_o,
  output logic [7:0]        stat_o,
  output logic              esr_ds_o,
  output logic [XLEN-1:0]   btr_o
);

  stat_t             stat_cur;
  trap_kind_e        kind;
  logic [RIDX_W-1:0] idx_d;
  logic [XLEN-1:0]   addr_d;
  logic [XLEN-1:0]   vec_d;
  stat_t             stat_d;

  logic              take;
  logic              exc_take;
  logic              btr_en;

  logic              redirect_q;
  logic [XLEN-1:0]   new_pc_q;
  logic [RIDX_W-1:0] ret_idx_q;
  logic [XLEN-1:0]   ret_addr_q;
  logic [7:0]        stat_q;
  logic              esr_ds_q;
  logic [XLEN-1:0]   btr_q;

  assign stat_cur = stat_t'(stat_i);

  trap_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .hwx_req    (hwx_req),
    .mmu_req    (mmu_req),
    .brk_req    (brk_req),
    .cfg_exc_en (cfg_exc_en),
    .stat       (stat_cur),
    .in_delay   (in_delay),
    .in_imm     (in_imm),
    .kind       (kind)
  );

  trap_resume_calc #(
    .XLEN     (XLEN),
    .RIDX_W   (RIDX_W),
    .VEC_BASE (VEC_BASE)
  ) u_resume (
    .kind     (kind),
    .cur_pc   (cur_pc),
    .in_delay (in_delay),
    .in_imm   (in_imm),
    .in_bimm  (in_bimm),
    .ret_idx  (idx_d),
    .ret_addr (addr_d),
    .vec_pc   (vec_d)
  );

  trap_status_upd u_stat (
    .kind     (kind),
    .stat_in  (stat_cur),
    .stat_out (stat_d)
  );

  // Clock enables
  always_comb begin
    take     = (kind != TK_NONE);
    exc_take = (kind == TK_HWX) || (kind == TK_MMU);
    btr_en   = exc_take & in_delay;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      new_pc_q   <= '0;
      ret_idx_q  <= '0;
      ret_addr_q <= '0;
      stat_q     <= '0;
      esr_ds_q   <= 1'b0;
      btr_q      <= '0;
    end else begin
      redirect_q <= take;
      if (take) begin
        new_pc_q   <= vec_d;
        ret_idx_q  <= idx_d;
        ret_addr_q <= addr_d;
        stat_q     <= stat_d;
      end
      if (exc_take) begin
        esr_ds_q <= in_delay;
      end
      if (btr_en) begin
        btr_q <= branch_tgt;
      end
    end
  end

  assign redirect_o = redirect_q;
  assign new_pc_o   = new_pc_q;
  assign ret_idx_o  = ret_idx_q;
  assign ret_addr_o = ret_addr_q;
  assign stat_o     = stat_q;
  assign esr_ds_o   = esr_ds_q;
  assign btr_o      = btr_q;

  // Input legality: no prefix inside a delay slot, no branch-imm flag outside one.
  p_flags_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_delay && in_imm) && !(in_bimm && !in_delay));

  p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (new_pc_o == VEC_BASE + XLEN'(OFF_IRQ)) ||
                   (new_pc_o == VEC_BASE + XLEN'(OFF_BRK)) ||
                   (new_pc_o == VEC_BASE + XLEN'(OFF_EXC)));

  p_mode_save_r11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> stat_o[6] == $past(stat_i[5]) && stat_o[4] == $past(stat_i[3])
                   && !stat_o[5] && !stat_o[3] && stat_o[7] == $past(stat_i[7]));

  p_exc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o && ret_idx_o == RIDX_W'(IDX_EXC) |-> stat_o[2]);

  p_irq_clears_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o && ret_idx_o == RIDX_W'(IDX_IRQ) |-> !stat_o[0]);

  p_hwx_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_exc_en && hwx_req && !mmu_req && !brk_req && !irq_req |=> !redirect_o);

  p_btr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmu_req || (hwx_req && cfg_exc_en)) |=> $stable(btr_o) && $stable(esr_ds_o));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_req && !hwx_req && !brk_req && !irq_req |=> !redirect_o);

endmodule

// File: tb/trap_entry_ctrl_tb_top.sv
module trap_entry_ctrl_tb_top;

  localparam logic [31:0] BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req, hwx_req, mmu_req, brk_req, cfg_exc_en;
  logic [31:0] cur_pc, branch_tgt;
  logic        in_delay, in_imm, in_bimm;
  logic [7:0]  stat_i;
  logic        redirect_o;
  logic [31:0] new_pc_o;
  logic [4:0]  ret_idx_o;
  logic [31:0] ret_addr_o;
  logic [7:0]  stat_o;
  logic        esr_ds_o;
  logic [31:0] btr_o;

  int n_chk = 0;
  int n_fail = 0;

  // expected values
  logic        e_redir;
  logic [31:0] e_pc, e_addr, e_btr;
  logic [4:0]  e_idx;
  logic [7:0]  e_stat;
  logic        e_esr;
  int          e_kind;   // 0 none 1 irq 2 brk 3 hwx 4 mmu

  always #2 clk = ~clk;

  trap_entry_ctrl #(.VEC_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .hwx_req(hwx_req),
    .mmu_req(mmu_req), .brk_req(brk_req), .cfg_exc_en(cfg_exc_en),
    .cur_pc(cur_pc), .branch_tgt(branch_tgt), .in_delay(in_delay),
    .in_imm(in_imm), .in_bimm(in_bimm), .stat_i(stat_i),
    .redirect_o(redirect_o), .new_pc_o(new_pc_o), .ret_idx_o(ret_idx_o),
    .ret_addr_o(ret_addr_o), .stat_o(stat_o), .esr_ds_o(esr_ds_o), .btr_o(btr_o)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int pick_kind();
    if (mmu_req) return 4;
    if (hwx_req && cfg_exc_en) return 3;
    if (brk_req) return 2;
    if (irq_req && stat_i[0] && !stat_i[2] && !stat_i[1] && !in_delay && !in_imm) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_status(input int k, input logic [7:0] s);
    logic [7:0] r;
    r = s;
    r[6] = s[5]; r[4] = s[3]; r[5] = 1'b0; r[3] = 1'b0;
    if (k == 1) r[0] = 1'b0;
    if (k == 2) r[1] = 1'b1;
    if (k >= 3) r[2] = 1'b1;
    return r;
  endfunction

  task automatic compute_exp();
    e_kind  = pick_kind();
    e_redir = (e_kind != 0);
    case (e_kind)
      1: begin e_idx = 5'd14; e_addr = cur_pc; e_pc = BASE + 32'h10; end
      2: begin e_idx = 5'd16; e_addr = cur_pc; e_pc = BASE + 32'h18; end
      3: begin e_idx = 5'd17; e_addr = cur_pc + 4; e_pc = BASE + 32'h20; end
      4: begin
        e_idx = 5'd17; e_pc = BASE + 32'h20;
        if (in_delay) e_addr = in_bimm ? cur_pc - 8 : cur_pc - 4;
        else if (in_imm) e_addr = cur_pc - 4;
        else e_addr = cur_pc;
      end
      default: ;
    endcase
    if (e_redir) e_stat = exp_status(e_kind, stat_i);
    if (e_kind >= 3) begin
      e_esr = in_delay;
      if (in_delay) e_btr = branch_tgt;
    end
  endtask

  task automatic check_outs();
    string tg;
    chk("R12 R2 R3 R4 redirect", {31'b0, redirect_o}, {31'b0, e_redir});
    if (e_redir) begin
      tg = (e_kind == 1) ? "R6" : (e_kind == 2) ? "R7" : (e_kind == 3) ? "R8" : "R9";
      chk("R5 vector", new_pc_o, e_pc);
      chk({tg, " R2 index"}, {27'b0, ret_idx_o}, {27'b0, e_idx});
      chk({tg, " resume"}, ret_addr_o, e_addr);
      chk({tg, " R11 status"}, {24'b0, stat_o}, {24'b0, e_stat});
    end
    chk("R10 esr", {31'b0, esr_ds_o}, {31'b0, e_esr});
    chk("R10 btr", btr_o, e_btr);
  endtask

  task automatic cycle();
    compute_exp();
    @(negedge clk);
    check_outs();
  endtask

  task automatic set_in(input logic irq, hwx, mmu, brk, cfg,
                        input logic [31:0] pc, tgt,
                        input logic dly, imm, bimm, input logic [7:0] st);
    irq_req = irq; hwx_req = hwx; mmu_req = mmu; brk_req = brk; cfg_exc_en = cfg;
    cur_pc = pc; branch_tgt = tgt; in_delay = dly; in_imm = imm; in_bimm = bimm;
    stat_i = st;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    set_in(1, 1, 1, 1, 1, 32'h400, 32'h800, 0, 0, 0, 8'h01);
    e_esr = 0; e_btr = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    chk("R1 reset redirect", {31'b0, redirect_o}, 32'd0);
    chk("R1 reset pc", new_pc_o, 32'd0);
    chk("R1 reset ret", ret_addr_o, 32'd0);
    chk("R1 reset idx/stat", {19'b0, ret_idx_o, stat_o}, 32'd0);
    chk("R1 reset btr", btr_o, 32'd0);
    chk("R1 reset esr", {31'b0, esr_ds_o}, 32'd0);
    set_in(0, 0, 0, 0, 1, 32'h400, 32'h800, 0, 0, 0, 8'h01);
    rst_n = 1'b1;
    cycle();  // R1: first cycle after reset idle

    // R6: interrupt accepted
    set_in(1, 0, 0, 0, 1, 32'h1000, 32'h0, 0, 0, 0, 8'h29); cycle();
    // R3: each blocking condition
    set_in(1, 0, 0, 0, 1, 32'h1004, 32'h0, 0, 0, 0, 8'h00); cycle();
    set_in(1, 0, 0, 0, 1, 32'h1004, 32'h0, 0, 0, 0, 8'h05); cycle();
    set_in(1, 0, 0, 0, 1, 32'h1004, 32'h0, 0, 0, 0, 8'h03); cycle();
    set_in(1, 0, 0, 0, 1, 32'h1004, 32'h0, 1, 0, 0, 8'h01); cycle();
    set_in(1, 0, 0, 0, 1, 32'h1004, 32'h0, 0, 1, 0, 8'h01); cycle();
    // R7: break
    set_in(0, 0, 0, 1, 1, 32'h2000, 32'h0, 0, 0, 0, 8'h08); cycle();
    // R10 R8: hw exception in delay slot captures target
    set_in(0, 1, 0, 0, 1, 32'h3000, 32'hCAFE_0000, 1, 0, 0, 8'h20); cycle();
    // R4: hw exception unsupported, no trap, captures held
    set_in(0, 1, 0, 0, 0, 32'h3100, 32'hDEAD_0000, 1, 0, 0, 8'h00); cycle();
    set_in(0, 1, 0, 1, 0, 32'h3100, 32'hDEAD_0000, 1, 0, 0, 8'h00); cycle();
    // R8 R10: hw exception without delay slot clears ds bit, btr held
    set_in(0, 1, 0, 0, 1, 32'h3200, 32'hBEEF_0000, 0, 0, 0, 8'h00); cycle();
    // R2: all requests at once
    set_in(1, 1, 1, 1, 1, 32'h4000, 32'h0, 0, 0, 0, 8'h01); cycle();
    set_in(1, 1, 0, 1, 1, 32'h4000, 32'h0, 0, 0, 0, 8'h01); cycle();
    set_in(1, 0, 0, 1, 1, 32'h4000, 32'h0, 0, 0, 0, 8'h01); cycle();
    // R9: four MMU resume cases
    set_in(0, 0, 1, 0, 1, 32'h5000, 32'h5500, 1, 0, 1, 8'h00); cycle();
    set_in(0, 0, 1, 0, 1, 32'h5000, 32'h5600, 1, 0, 0, 8'h00); cycle();
    set_in(0, 0, 1, 0, 1, 32'h5000, 32'h0, 0, 1, 0, 8'h00); cycle();
    set_in(0, 0, 1, 0, 1, 32'h5000, 32'h0, 0, 0, 0, 8'hFF); cycle();
    // R12: idle after traps
    set_in(0, 0, 0, 0, 1, 32'h6000, 32'h0, 0, 0, 0, 8'h01); cycle();

    for (int i = 0; i < 3000; i++) begin
      logic dly, imm, bimm;
      dly  = ($urandom % 4) == 0;
      imm  = dly ? 1'b0 : (($urandom % 5) == 0);
      bimm = dly ? 1'($urandom) : 1'b0;
      set_in(($urandom % 3) == 0, ($urandom % 6) == 0, ($urandom % 8) == 0,
             ($urandom % 6) == 0, ($urandom % 4) != 0, $urandom, $urandom,
             dly, imm, bimm, 8'($urandom));
      cycle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule